// File: doc/BRIEF.md
# Serial Display Link PLL Sequencer

This block sequences the power-up and power-down of a serial display link and the PLL that clocks it. On a start request it drives the link configuration fields and enables the free-running pixel clock. It then releases the PLL from reset and waits a short settle time before it raises the PLL go bit. Three handshakes follow. The block waits for the lock-request busy flag to clear, then for the PLL to report lock, then for the link to report that its reset has finished. Each handshake has its own timeout.

If a handshake times out, the block unwinds only what it has switched on so far and reports a timeout. A stop request shuts the link down in a fixed order. The analog PLL and the link report their status on plain input ports. Every control and configuration field leaves the block on a plain output port, so a register bank or a controller can wrap it.

Top module: `serlink_pll_seq`

## Requirements
- R1: After reset every enable, the go bit, `done_o`, `timeout_o`, `busy_o` and every configuration field are 0.
- R2: A start request with `pairs_i` between 1 and 3 sets the fixed configuration and drives `cfg_pairsel_o` to the pair count minus one. The fixed configuration is pixel divider 0xF, bandwidth select 2, frequency select 7, N value 0xB and M value 0xB4. A start request with `pairs_i` = 0 is ignored.
- R3: During bring-up, `pclk_en_o` rises exactly one cycle before `pll_rel_o` rises.
- R4: `pll_go_o` rises no earlier than SETTLE_CYC cycles after `pll_rel_o` rises.
- R5: `pll_go_o` stays high while `lock_busy_i` is high. Outside the failure unwind, it is cleared only after `lock_busy_i` is seen low.
- R6: `panel_en_o` rises only after `pll_locked_i` has been seen high and `pll_go_o` is low.
- R7: When `link_rst_done_i` is seen high, `done_o` goes high. On success `pclk_en_o`, `pll_rel_o` and `panel_en_o` stay high and `busy_o` drops.
- R8: Each of the three waits gives up after TIMEOUT_CYC cycles without its condition. `timeout_o` then rises within a few cycles of that limit.
- R9: The unwind after a timeout runs in order:
  - if the link-reset wait was the one that timed out, `panel_en_o` drops first;
  - then `pll_rel_o` and `pll_go_o` clear;
  - then `pclk_en_o` clears and `timeout_o` rises.
  At the end of the unwind every enable is 0 and `done_o` is 0.
- R10: A stop request clears `done_o` and drops `panel_en_o`. One cycle later `pclk_en_o` drops, and one cycle after that `pll_rel_o` clears.
- R11: `busy_o` is high for the whole of a sequence. Start and stop requests that arrive while `busy_o` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Bring-up request |
| stop_i | input | 1 | Shutdown request |
| pairs_i | input | 2 | Data-pair count, 1 to 3 valid |
| lock_busy_i | input | 1 | PLL lock request still pending |
| pll_locked_i | input | 1 | PLL reports lock |
| link_rst_done_i | input | 1 | Link reset finished |
| cfg_pdiv_o | output | 5 | Pixel divider field |
| cfg_pairsel_o | output | 2 | Data-pair select field (count minus one) |
| cfg_bwsel_o | output | 2 | Bandwidth select field |
| cfg_freqsel_o | output | 4 | PLL frequency select field |
| cfg_regn_o | output | 6 | PLL N value field |
| cfg_regm_o | output | 10 | PLL M value field |
| pll_rel_o | output | 1 | PLL reset release |
| pll_go_o | output | 1 | PLL go bit |
| pclk_en_o | output | 1 | Free-running pixel clock enable |
| panel_en_o | output | 1 | Panel output enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Link up after successful bring-up |
| timeout_o | output | 1 | Last bring-up ended in a timeout |

## Verification
The checker tests the ordering rules on every cycle:
- the pixel clock comes before reset release;
- the settle gap comes before go;
- go is held while the PLL is busy;
- panel enable needs lock;
- success needs link-reset done;
- the outputs are all off while a timeout is reported.

Only the bench scenarios can show the rest:
- which wait failed and whether the unwind matched that stage;
- the timeout length;
- the exact order and spacing of the shutdown;
- that requests arriving mid-sequence leave the result unchanged.

// File: rtl/serlink_pll_seq.sv
module serlink_pll_seq #(
  parameter int TIMEOUT_CYC = 50_000_000,
  parameter int SETTLE_CYC  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [1:0] pairs_i,
  input  logic       lock_busy_i,
  input  logic       pll_locked_i,
  input  logic       link_rst_done_i,
  output logic [4:0] cfg_pdiv_o,
  output logic [1:0] cfg_pairsel_o,
  output logic [1:0] cfg_bwsel_o,
  output logic [3:0] cfg_freqsel_o,
  output logic [5:0] cfg_regn_o,
  output logic [9:0] cfg_regm_o,
  output logic       pll_rel_o,
  output logic       pll_go_o,
  output logic       pclk_en_o,
  output logic       panel_en_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       timeout_o
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  typedef enum logic [3:0] {
    IDLE, REL, SETTLE, REQ, LOCK, LINK, FREL, FPCLK, SPCLK, SREL
  } st_t;

  st_t           st;
  logic [TW-1:0] cnt;
  logic          cfg_set;
  logic [1:0]    pairsel;

  wire expired = (cnt == TW'(TIMEOUT_CYC - 1));
  wire settled = (cnt == TW'(SETTLE_CYC - 1));

  assign busy_o        = (st != IDLE);
  assign cfg_pairsel_o = pairsel;
  assign cfg_pdiv_o    = cfg_set ? 5'h0F  : 5'h00;
  assign cfg_bwsel_o   = cfg_set ? 2'd2   : 2'd0;
  assign cfg_freqsel_o = cfg_set ? 4'd7   : 4'd0;
  assign cfg_regn_o    = cfg_set ? 6'h0B  : 6'h00;
  assign cfg_regm_o    = cfg_set ? 10'hB4 : 10'h000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= IDLE;
      cnt        <= '0;
      cfg_set    <= 1'b0;
      pairsel    <= 2'd0;
      pll_rel_o  <= 1'b0;
      pll_go_o   <= 1'b0;
      pclk_en_o  <= 1'b0;
      panel_en_o <= 1'b0;
      done_o     <= 1'b0;
      timeout_o  <= 1'b0;
    end else begin
      case (st)
        IDLE: begin
          if (start_i && pairs_i != 2'd0) begin
            cfg_set   <= 1'b1;
            pairsel   <= pairs_i - 2'd1;
            pclk_en_o <= 1'b1;
            done_o    <= 1'b0;
            timeout_o <= 1'b0;
            st        <= REL;
          end else if (stop_i) begin
            panel_en_o <= 1'b0;
            done_o     <= 1'b0;
            timeout_o  <= 1'b0;
            st         <= SPCLK;
          end
        end
        REL: begin
          pll_rel_o <= 1'b1;
          cnt       <= '0;
          st        <= SETTLE;
        end
        SETTLE: begin
          if (settled) begin
            pll_go_o <= 1'b1;
            cnt      <= '0;
            st       <= REQ;
          end else cnt <= cnt + 1'b1;
        end
        REQ: begin
          if (!lock_busy_i) begin
            pll_go_o <= 1'b0;
            cnt      <= '0;
            st       <= LOCK;
          end else if (expired) st <= FREL;
          else cnt <= cnt + 1'b1;
        end
        LOCK: begin
          if (pll_locked_i) begin
            panel_en_o <= 1'b1;
            cnt        <= '0;
            st         <= LINK;
          end else if (expired) st <= FREL;
          else cnt <= cnt + 1'b1;
        end
        LINK: begin
          if (link_rst_done_i) begin
            done_o <= 1'b1;
            st     <= IDLE;
          end else if (expired) begin
            panel_en_o <= 1'b0;
            st         <= FREL;
          end else cnt <= cnt + 1'b1;
        end
        FREL: begin
          pll_rel_o <= 1'b0;
          pll_go_o  <= 1'b0;
          st        <= FPCLK;
        end
        FPCLK: begin
          pclk_en_o <= 1'b0;
          timeout_o <= 1'b1;
          st        <= IDLE;
        end
        SPCLK: begin
          pclk_en_o <= 1'b0;
          st        <= SREL;
        end
        SREL: begin
          pll_rel_o <= 1'b0;
          pll_go_o  <= 1'b0;
          st        <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serlink_pll_seq_chk.sv
module serlink_pll_seq_chk #(
  parameter int SETTLE_CYC = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       lock_busy_i,
  input logic       pll_locked_i,
  input logic       link_rst_done_i,
  input logic       pll_rel_o,
  input logic       pll_go_o,
  input logic       pclk_en_o,
  input logic       panel_en_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       timeout_o,
  input logic [1:0] cfg_pairsel_o
);
  localparam int AW = $clog2(SETTLE_CYC + 2);
  logic [AW-1:0] rel_age;

  always_ff @(posedge clk) begin
    if (!rst_n) rel_age <= '0;
    else if (!pll_rel_o) rel_age <= '0;
    else if (rel_age != {AW{1'b1}}) rel_age <= rel_age + 1'b1;
  end

  a_r3_pclk_before_rel: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_rel_o) |-> pclk_en_o && $past(pclk_en_o));
  a_r4_settle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_go_o) |-> (int'(rel_age) >= SETTLE_CYC) && pclk_en_o);
  a_r5_go_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_go_o) && !$fell(pll_rel_o) |-> !$past(lock_busy_i));
  a_r6_panel_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(panel_en_o) |-> $past(pll_locked_i) && !pll_go_o);
  a_r7_done_needs_link: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(link_rst_done_i) && panel_en_o && !timeout_o);
  a_r9_timeout_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> !pclk_en_o && !pll_rel_o && !pll_go_o && !panel_en_o && !done_o);
  a_r10_pclk_after_panel: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pclk_en_o) |-> !panel_en_o);
  a_r2_pairsel_valid: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> cfg_pairsel_o != 2'd3);
endmodule

bind serlink_pll_seq serlink_pll_seq_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (.*);

// File: tb/serlink_pll_seq_tb.sv
module serlink_pll_seq_tb;
  localparam int T = 40;
  localparam int S = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, stop_i = 1'b0;
  logic [1:0] pairs_i = 2'd1;
  logic lock_busy_i = 1'b0, pll_locked_i = 1'b0, link_rst_done_i = 1'b0;
  logic [4:0] cfg_pdiv_o;
  logic [1:0] cfg_pairsel_o, cfg_bwsel_o;
  logic [3:0] cfg_freqsel_o;
  logic [5:0] cfg_regn_o;
  logic [9:0] cfg_regm_o;
  logic pll_rel_o, pll_go_o, pclk_en_o, panel_en_o, busy_o, done_o, timeout_o;

  serlink_pll_seq #(.TIMEOUT_CYC(T), .SETTLE_CYC(S)) u_dut (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int d1 = 0, d2 = 0, d3 = 0;
  int cyc = 0;
  int t_pclk_r, t_rel_r, t_go_r, t_tmo_r, t_panel_f, t_pclk_f, t_rel_f;
  bit panel_seen;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_phase(input int a, input int b, input int c);
    if (a < 0 || a >= T) return 1;
    if (b < 0 || b >= T) return 2;
    if (c < 0 || c >= T) return 3;
    return 0;
  endfunction

  // status model and edge monitor
  initial begin
    int bcnt = 0, lcnt = 0, kcnt = 0;
    bit seen_go = 0;
    logic p_pclk = 0, p_rel = 0, p_go = 0, p_panel = 0, p_tmo = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (pclk_en_o && !p_pclk) t_pclk_r = cyc;
      if (!pclk_en_o && p_pclk) t_pclk_f = cyc;
      if (pll_rel_o && !p_rel) t_rel_r = cyc;
      if (!pll_rel_o && p_rel) t_rel_f = cyc;
      if (pll_go_o && !p_go) t_go_r = cyc;
      if (timeout_o && !p_tmo) t_tmo_r = cyc;
      if (panel_en_o && !p_panel) panel_seen = 1;
      if (!panel_en_o && p_panel) t_panel_f = cyc;
      {p_pclk, p_rel, p_go, p_panel, p_tmo} = {pclk_en_o, pll_rel_o, pll_go_o, panel_en_o, timeout_o};
      if (!pll_rel_o) seen_go = 0;
      else if (pll_go_o) seen_go = 1;
      lock_busy_i = pll_go_o && (d1 < 0 || bcnt < d1);
      bcnt = pll_go_o ? bcnt + 1 : 0;
      pll_locked_i = seen_go && !pll_go_o && d2 >= 0 && lcnt >= d2;
      lcnt = (seen_go && !pll_go_o) ? lcnt + 1 : 0;
      link_rst_done_i = panel_en_o && d3 >= 0 && kcnt >= d3;
      kcnt = panel_en_o ? kcnt + 1 : 0;
    end
  end

  task automatic wait_idle(input string tag);
    int n = 0;
    while (busy_o && n < 3000) begin @(negedge clk); n++; end
    if (busy_o) check({tag, " stuck busy"}, 1, 0);
  endtask

  task automatic do_stop();
    @(negedge clk); stop_i = 1;
    @(negedge clk); stop_i = 0;
    check("R11 busy during stop", busy_o, 1);
    wait_idle("R10");
    check("R10 pclk one cycle after panel", t_pclk_f - t_panel_f, 1);
    check("R10 rel one cycle after pclk", t_rel_f - t_pclk_f, 1);
    check("R10 all off", {pclk_en_o, pll_rel_o, panel_en_o, pll_go_o, done_o}, 0);
  endtask

  task automatic bringup(input int cnt, input int a, input int b, input int c, input bit poke);
    int ph;
    if (pclk_en_o) do_stop();
    d1 = a; d2 = b; d3 = c;
    panel_seen = 0;
    ph = exp_phase(a, b, c);
    @(negedge clk); start_i = 1; pairs_i = 2'(cnt);
    @(negedge clk); start_i = 0;
    check("R11 busy after start", busy_o, 1);
    if (poke) begin
      repeat (S + 2) @(negedge clk);
      start_i = 1; stop_i = 1; pairs_i = 2'd3;
      @(negedge clk); start_i = 0; stop_i = 0;
    end
    wait_idle("R7");
    check("R2 pairsel", cfg_pairsel_o, cnt - 1);
    check("R2 fixed cfg", {cfg_pdiv_o, cfg_bwsel_o, cfg_freqsel_o, cfg_regn_o, cfg_regm_o},
          {5'h0F, 2'd2, 4'd7, 6'h0B, 10'hB4});
    check("R3 pclk before rel", t_rel_r - t_pclk_r, 1);
    check("R4 settle gap", int'(t_go_r - t_rel_r >= S), 1);
    if (ph == 0) begin
      check("R7 done", done_o, 1);
      check("R7 enables held", {pclk_en_o, pll_rel_o, panel_en_o, pll_go_o, timeout_o}, 5'b11100);
    end else begin
      check("R9 timeout flag", {timeout_o, done_o}, 2'b10);
      check("R9 all off", {pclk_en_o, pll_rel_o, panel_en_o, pll_go_o}, 0);
      check("R9 panel reached only in link stage", panel_seen, int'(ph == 3));
      if (ph == 1) check("R8 timeout length", int'(t_tmo_r - t_go_r >= T && t_tmo_r - t_go_r <= T + 4), 1);
    end
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    check("watchdog", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {pclk_en_o, pll_rel_o, pll_go_o, panel_en_o, busy_o, done_o, timeout_o}, 0);
    check("R1 reset cfg", {cfg_pdiv_o, cfg_pairsel_o, cfg_bwsel_o, cfg_freqsel_o, cfg_regn_o, cfg_regm_o}, 0);
    rst_n = 1;
    @(negedge clk);
    pairs_i = 2'd0; start_i = 1;
    @(negedge clk); start_i = 0;
    check("R2 zero pairs ignored", {busy_o, pclk_en_o, cfg_pdiv_o}, 0);
    bringup(1, 0, 0, 0, 0);
    bringup(2, 5, 7, 3, 0);
    bringup(3, -1, 0, 0, 0);
    bringup(2, 2, -1, 0, 0);
    bringup(1, 3, 4, -1, 0);
    bringup(3, 60, 0, 0, 0);
    bringup(2, 1, 2, 10, 1);
    check("R11 pairsel kept after ignored start", cfg_pairsel_o, 1);
    do_stop();
    bringup(1, 2, 2, 60, 1);
    for (int i = 0; i < 12; i++) begin
      int v[3];
      for (int k = 0; k < 3; k++) begin
        int r = int'($urandom % 10);
        v[k] = (r < 7) ? int'($urandom % 16) : (r < 9 ? -1 : 60);
      end
      bringup(1 + int'($urandom % 3), v[0], v[1], v[2], 0);
    end
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule